// File: doc/BRIEF.md
# Bus Fault Responder

This block is the catch-all target of a single-manager AHB-Lite style bus. The address decoder selects it whenever no real subordinate owns the address on the bus. It accepts no data and holds no storage. Every real transfer that reaches it is refused with the two-cycle error response, so a stray access ends in a clean, reportable fault and never leaves the bus hung. IDLE and BUSY transfers, and cycles in which it is not selected, get a zero-wait OKAY.

A small finite-state machine with three named states does the work:

- `ST_READY`: drives OKAY with the ready output high.
- `ST_FAULT_HOLD`: the first error cycle. It drives ERROR with the ready output low, which holds the bus so the manager can cancel its pipelined next transfer.
- `ST_FAULT_DONE`: the second error cycle. It drives ERROR with the ready output high, which completes the failed transfer.

The transitions are:

- `ST_READY` goes to `ST_FAULT_HOLD` when an address phase is accepted, and otherwise stays in `ST_READY`.
- `ST_FAULT_HOLD` always goes to `ST_FAULT_DONE`.
- `ST_FAULT_DONE` goes to `ST_FAULT_HOLD` when an address phase is accepted in that cycle, and otherwise returns to `ST_READY`.

An address phase is accepted only when three inputs are high together: the select, the bus-wide ready, and the top bit of the transfer type. That top bit is high for NONSEQ (2'b10) and SEQ (2'b11). The response output is one bit, with 0 for OKAY and 1 for ERROR. The read data output is zero at all times.

Top module: `bus_fault_responder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ready_out_o` is 1 and `resp_o` is 0 (OKAY).
- R2: From `ST_READY`, an accepted NONSEQ (2'b10) or SEQ (2'b11) address phase makes the next cycle show `resp_o`=1 (ERROR) with `ready_out_o`=0.
- R3: The cycle after a first error cycle always shows `resp_o`=1 with `ready_out_o`=1, which completes the failed transfer.
- R4: A selected IDLE (2'b00) or BUSY (2'b01) transfer with the bus ready high gives OKAY with `ready_out_o`=1 in the next cycle.
- R5: A cycle in which `sel_i` is low gives OKAY with `ready_out_o`=1 in the next cycle, whatever the transfer type.
- R6: While `bus_ready_i` is low outside an error sequence, a selected NONSEQ or SEQ transfer is not accepted, and the next cycle shows OKAY with the ready output high.
- R7: Inputs seen during the first error cycle are ignored. `ST_FAULT_HOLD` moves to `ST_FAULT_DONE` even if an acceptable transfer is presented.
- R8: A NONSEQ or SEQ transfer accepted in the second error cycle starts a new first error cycle directly afterwards, with no OKAY cycle between the two sequences.
- R9: `rdata_o` is all zeros in every cycle.
- R10: `ready_out_o` is never low for two consecutive cycles, so the bus cannot hang.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Decoder select for this target |
| trans_i | input | TRANS_W | Transfer type; top bit high means NONSEQ or SEQ |
| bus_ready_i | input | 1 | Bus-wide ready; high when the previous transfer completes |
| ready_out_o | output | 1 | Ready driven by this target |
| resp_o | output | 1 | Response: 0 for OKAY, 1 for ERROR |
| rdata_o | output | DATA_W | Read data, always zero |

## Verification
The bench builds the block with DATA_W set to 64 and TRANS_W left at 2. The wide data bus checks that the zero read data covers every lane, not only a 32-bit slice. A two-bit transfer type keeps all four transfer codes within reach of the random stimulus, so IDLE, BUSY, NONSEQ and SEQ each meet every state. The directed cases force back-to-back error sequences, an acceptable-looking transfer during the first error cycle, and selected transfers while the bus ready is low.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

    // Response encoding on the single-bit response line
    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;

    // Responder states
    typedef enum logic [1:0] {
        ST_READY      = 2'd0,
        ST_FAULT_HOLD = 2'd1,
        ST_FAULT_DONE = 2'd2
    } dfr_state_e;

    // Output pair driven for each state
    typedef struct packed {
        logic ready;
        logic resp;
    } dfr_out_t;

endpackage

// File: rtl/dfr_accept.sv
module dfr_accept #(
    parameter int TRANS_W = 2
) (
    input  logic               sel_i,
    input  logic [TRANS_W-1:0] trans_i,
    input  logic               bus_ready_i,
    output logic               accept_o
);

    // Position of the bit that separates active transfers (NONSEQ/SEQ) from IDLE/BUSY
    localparam int ACTIVE_BIT = TRANS_W - 1;

    logic active_kind;
    logic unused_low_bits;

    assign active_kind     = trans_i[ACTIVE_BIT];
    assign unused_low_bits = ^trans_i[ACTIVE_BIT-1:0];

    // An address phase is taken only when selected, the bus is ready and the transfer is real
    always_comb begin
        accept_o = sel_i & bus_ready_i & active_kind;
    end

endmodule

// File: rtl/dfr_fsm.sv
module dfr_fsm
    import dfr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic ready_o,
    output logic resp_o
);

    dfr_state_e state_q;
    dfr_state_e state_d;
    dfr_out_t   out_c;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (accept_i) state_d = ST_FAULT_HOLD;
                else          state_d = ST_READY;
            end
            ST_FAULT_HOLD: begin
                state_d = ST_FAULT_DONE;
            end
            ST_FAULT_DONE: begin
                if (accept_i) state_d = ST_FAULT_HOLD;
                else          state_d = ST_READY;
            end
            default: begin
                state_d = ST_READY;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Outputs per state
    always_comb begin
        out_c = '{ready: 1'b1, resp: RESP_OKAY};
        unique case (state_q)
            ST_READY:      out_c = '{ready: 1'b1, resp: RESP_OKAY};
            ST_FAULT_HOLD: out_c = '{ready: 1'b0, resp: RESP_ERROR};
            ST_FAULT_DONE: out_c = '{ready: 1'b1, resp: RESP_ERROR};
            default:       out_c = '{ready: 1'b1, resp: RESP_OKAY};
        endcase
    end

    assign ready_o = out_c.ready;
    assign resp_o  = out_c.resp;

    // An accepted phase is answered by the stalled error cycle
    AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && accept_i) |=> (resp_o && !ready_o)); // R2

    // The stalled error cycle is always followed by the completing error cycle
    AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o && !ready_o) |=> (resp_o && ready_o)); // R3

    // Nothing accepted outside the stall gives a plain OKAY
    AST_OKAY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !accept_i) |=> (ready_o && !resp_o)); // R4

    // The ready line never stays low for two cycles
    AST_NO_HANG: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> ready_o); // R10

    // OKAY is never shown with the ready line low
    AST_OKAY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_o |-> ready_o); // R1

endmodule

// File: rtl/bus_fault_responder.sv
module bus_fault_responder #(
    parameter int DATA_W  = 32,
    parameter int TRANS_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic [TRANS_W-1:0] trans_i,
    input  logic               bus_ready_i,
    output logic               ready_out_o,
    output logic               resp_o,
    output logic [DATA_W-1:0]  rdata_o
);

    logic accept;

    dfr_accept #(
        .TRANS_W (TRANS_W)
    ) u_accept (
        .sel_i       (sel_i),
        .trans_i     (trans_i),
        .bus_ready_i (bus_ready_i),
        .accept_o    (accept)
    );

    dfr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .ready_o  (ready_out_o),
        .resp_o   (resp_o)
    );

    // No storage behind this target: read data is tied low
    assign rdata_o = '0;

    // An error sequence never starts without a selected access
    AST_SEL_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_out_o && !sel_i) |=> ready_out_o); // R5

endmodule

// File: tb/test_bus_fault_responder.sv
`timescale 1ns/1ps
module test_bus_fault_responder;

    localparam int DATA_W  = 64;
    localparam int TRANS_W = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sel_i = 1'b0;
    logic [TRANS_W-1:0] trans_i = '0;
    logic               bus_ready_i = 1'b1;
    logic               ready_out_o;
    logic               resp_o;
    logic [DATA_W-1:0]  rdata_o;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_st   = 0;   // 0: OKAY, 1: first error cycle, 2: second error cycle
    int low_run  = 0;
    string tag   = "R1";

    always #2.5 clk = ~clk;

    bus_fault_responder #(.DATA_W(DATA_W), .TRANS_W(TRANS_W)) i_bus_fault_responder (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .trans_i(trans_i),
        .bus_ready_i(bus_ready_i), .ready_out_o(ready_out_o), .resp_o(resp_o),
        .rdata_o(rdata_o)
    );

    function automatic int next_state(int st, logic s, logic [TRANS_W-1:0] t, logic r);
        if (st == 1) return 2;
        if (s && r && t[TRANS_W-1]) return 1;
        return 0;
    endfunction

    function automatic logic [1:0] exp_out(int st);
        // {ready, resp}
        if (st == 1) return 2'b01;
        if (st == 2) return 2'b11;
        return 2'b10;
    endfunction

    function automatic string pick_tag(int st, logic s, logic [TRANS_W-1:0] t, logic r);
        if (st == 1) return (s && r && t[TRANS_W-1]) ? "R7" : "R3";
        if (s && r && t[TRANS_W-1]) return (st == 2) ? "R8" : "R2";
        if (!s) return "R5";
        if (!r) return "R6";
        return "R4";
    endfunction

    task automatic check(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare outputs for the current state, then drive the next inputs
    task automatic cycle(logic s, logic [TRANS_W-1:0] t, logic r);
        logic [1:0] e;
        @(negedge clk);
        e = exp_out(exp_st);
        check({ready_out_o, resp_o} == e, tag, {62'd0, ready_out_o, resp_o}, {62'd0, e});
        check(rdata_o == '0, "R9", rdata_o, '0);
        low_run = ready_out_o ? 0 : low_run + 1;
        check(low_run < 2, "R10", low_run, 1);
        sel_i = s; trans_i = t; bus_ready_i = r;
        tag    = pick_tag(exp_st, s, t, r);
        exp_st = next_state(exp_st, s, t, r);
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7319));
        // R1: reset values while reset is held
        repeat (3) @(negedge clk);
        check({ready_out_o, resp_o} == 2'b10, "R1", {62'd0, ready_out_o, resp_o}, 64'd2);
        sel_i = 1'b1; trans_i = 2'b10; bus_ready_i = 1'b1;
        @(negedge clk);
        check({ready_out_o, resp_o} == 2'b10, "R1", {62'd0, ready_out_o, resp_o}, 64'd2);
        sel_i = 1'b0; trans_i = 2'b00;
        rst_n = 1'b1;
        exp_st = 0; tag = "R1";

        // R2/R3: single NONSEQ, then idle
        cycle(1, 2'b10, 1);
        cycle(0, 2'b00, 0);
        cycle(0, 2'b00, 1);
        cycle(0, 2'b00, 1);
        // R8: SEQ accepted in second error cycle
        cycle(1, 2'b11, 1);
        cycle(1, 2'b11, 0);
        cycle(1, 2'b10, 1);
        cycle(0, 2'b00, 0);
        cycle(0, 2'b00, 1);
        // R7: acceptable inputs during first error cycle are ignored
        cycle(1, 2'b10, 1);
        cycle(1, 2'b10, 1);
        cycle(0, 2'b00, 1);
        cycle(0, 2'b00, 1);
        // R4: IDLE and BUSY selected
        cycle(1, 2'b00, 1);
        cycle(1, 2'b01, 1);
        // R6: active transfer while bus ready low
        cycle(1, 2'b10, 0);
        cycle(1, 2'b11, 0);
        // R5: unselected active transfer
        cycle(0, 2'b10, 1);
        cycle(0, 2'b11, 1);
        cycle(0, 2'b00, 1);

        // Constrained random traffic; bus ready follows this target except for occasional stalls elsewhere
        for (int i = 0; i < 3000; i++) begin
            logic s, r;
            logic [TRANS_W-1:0] t;
            s = ($urandom % 4) != 0;
            t = TRANS_W'($urandom);
            r = (exp_st == 1) ? 1'b0 : (($urandom % 5) != 0);
            cycle(s, t, r);
        end
        cycle(0, 2'b00, 1);
        cycle(0, 2'b00, 1);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule